// File: doc/BRIEF.md
# Two-Strobe Transmit Word Queue

This block is the word buffer in front of a serial transmit sequencer. A host with a 16-bit data bus writes each 31-bit word in two steps. A low-half strobe captures bus bits [15:0] into a holding register. A following high-half strobe supplies bus bits [14:0] as word bits [30:16], and that strobe commits the finished word to the next free slot of an eight-entry first-in first-out store. The sequencer always sees the oldest stored word on `head_word`. A one-cycle `pop_req` retires that word and moves the read pointer on.

The strobe pairing is handled by a two-state machine. In `ST_WAIT_LO` no low half is pending. A low-half strobe moves it to `ST_HOLD_LO` (transition *capture*), provided the store is not full. In `ST_HOLD_LO`, a high-half strobe commits the word and returns the machine to `ST_WAIT_LO` (transition *commit*). A repeated low-half strobe instead stays in `ST_HOLD_LO` and replaces the pending half (transition *recapture*). A high-half strobe in `ST_WAIT_LO` leaves the state unchanged (transition *orphan*). Reset forces `ST_WAIT_LO` from either state.

The store drives `tx_ready` back to the host. The flag is high only when every queued word has been handed to the sequencer. While it is low, the host may fill only the slots still free. It can tell how many are free from `level` and `full`.

Top module: `tx_word_buffer`

## Requirements
- R1: Synchronous active-low reset empties the store (`level`=0, `full`=0, `tx_ready`=1) and discards any pending low half, so a high-half strobe right after reset commits nothing.
- R2: A low-half strobe captures `host_data[15:0]` as word bits [15:0]. A later high-half strobe supplies `host_data[14:0]` as word bits [30:16] and commits the word, and `level` rises by one on that clock edge.
- R3: A high-half strobe with no pending low half is ignored. Each low half pairs with exactly one high half, so a second high-half strobe after a commit adds nothing.
- R4: With 8 words stored, `full` is 1 and all load strobes are ignored: `level` and the stored words are unchanged.
- R5: A second low-half strobe before the high half replaces the pending low half.
- R6: `tx_ready` is 1 exactly when `level` is 0. It rises in the cycle after the last stored word is popped.
- R7: `head_word` shows the oldest stored word. `pop_req` removes it on the clock edge, and `pop_req` on an empty store is ignored.
- R8: Words leave in the order they were committed. A commit and a pop on the same edge leave `level` unchanged.
- R9: `host_data[15]` has no effect during a high-half strobe.
- R10: If both strobes arrive on the same edge, the high-half strobe takes priority. With no pending half, only the low half acts and is captured. With a half pending, the word commits and the low half is dropped.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Synchronous active-low reset |
| host_data | input | 16 | Host data bus |
| load_lo | input | 1 | Low-half load strobe |
| load_hi | input | 1 | High-half load strobe; commits the word |
| pop_req | input | 1 | One-cycle request from the sequencer to retire the oldest word |
| head_word | output | 31 | Oldest stored word |
| level | output | 4 | Number of stored words |
| full | output | 1 | All slots occupied |
| tx_ready | output | 1 | All queued words sent (store empty) |

## Verification
The bench builds the block with its default sizes: 8 slots, 31-bit words and a 16-bit bus. The full boundary is therefore reached after only eight strobe pairs. That makes it cheap to drive the store to capacity, try loads against it, and drain it while checking the order of every word. The 15-bit high half keeps the unused top bus bit reachable, so the bench drives it high on purpose. Pending-half cases are reached through their strobe sequences: reset while a half is pending, both strobes on one edge, and a commit on the same edge as a pop.

// File: rtl/tx_buf_pkg.sv
package tx_buf_pkg;

    typedef enum logic {
        ST_WAIT_LO = 1'b0,
        ST_HOLD_LO = 1'b1
    } half_state_t;

endpackage

// File: rtl/tx_half_fsm.sv
module tx_half_fsm
    import tx_buf_pkg::*;
#(
    parameter int WORD_W = 31,
    parameter int BUS_W  = 16
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic [BUS_W-1:0]  host_data,
    input  logic              load_lo,
    input  logic              load_hi,
    input  logic              store_full,
    output logic              commit,
    output logic [WORD_W-1:0] commit_word
);

    localparam int HI_W = WORD_W - BUS_W;

    half_state_t state_q, state_d;
    logic [BUS_W-1:0] lo_half_q;
    logic             take_lo;

    // State register
    always_ff @(posedge clk) begin
        if (!rst_n) state_q <= ST_WAIT_LO;
        else        state_q <= state_d;
    end

    // Next-state logic: the high-half strobe is considered first
    always_comb begin
        state_d = state_q;
        take_lo = 1'b0;
        unique case (state_q)
            ST_WAIT_LO: begin
                if (load_lo && !store_full) begin
                    take_lo = 1'b1;
                    state_d = ST_HOLD_LO;
                end
            end
            ST_HOLD_LO: begin
                if (load_hi) begin
                    if (!store_full) state_d = ST_WAIT_LO;
                end else if (load_lo) begin
                    take_lo = 1'b1;
                end
            end
            default: state_d = ST_WAIT_LO;
        endcase
    end

    // Pending low half
    always_ff @(posedge clk) begin
        if (!rst_n)       lo_half_q <= '0;
        else if (take_lo) lo_half_q <= host_data;
    end

    // Outputs
    always_comb begin
        commit      = 1'b0;
        commit_word = {host_data[HI_W-1:0], lo_half_q};
        unique case (state_q)
            ST_WAIT_LO: commit = 1'b0;
            ST_HOLD_LO: commit = load_hi && !store_full;
            default:    commit = 1'b0;
        endcase
    end

    AST_ORPHAN_HI: assert property (@(posedge clk) disable iff (!rst_n)
        (state_q == ST_WAIT_LO && !load_lo) |=> (state_q == ST_WAIT_LO)); // R3

    AST_COMMIT_CLEARS: assert property (@(posedge clk) disable iff (!rst_n)
        commit |=> (state_q == ST_WAIT_LO)); // R2

    AST_RECAPTURE_STAYS: assert property (@(posedge clk) disable iff (!rst_n)
        (state_q == ST_HOLD_LO && load_lo && !load_hi) |=> (state_q == ST_HOLD_LO)); // R5

endmodule

// File: rtl/tx_word_store.sv
module tx_word_store #(
    parameter int DEPTH  = 8,
    parameter int WORD_W = 31
) (
    input  logic                       clk,
    input  logic                       rst_n,
    input  logic                       push,
    input  logic [WORD_W-1:0]          push_word,
    input  logic                       pop,
    output logic [WORD_W-1:0]          head_word,
    output logic [$clog2(DEPTH+1)-1:0] level,
    output logic                       full,
    output logic                       empty
);

    localparam int PTR_W = (DEPTH > 1) ? $clog2(DEPTH) : 1;
    localparam int CNT_W = $clog2(DEPTH + 1);
    localparam logic [PTR_W-1:0] LAST_SLOT = PTR_W'(DEPTH - 1);
    localparam logic [CNT_W-1:0] CAP       = CNT_W'(DEPTH);

    logic [WORD_W-1:0] slots [DEPTH];
    logic [PTR_W-1:0]  wr_ptr, rd_ptr;
    logic [CNT_W-1:0]  count;
    logic              do_push, do_pop;

    function automatic logic [PTR_W-1:0] step_ptr(input logic [PTR_W-1:0] p);
        return (p == LAST_SLOT) ? '0 : p + 1'b1;
    endfunction

    assign full    = (count == CAP);
    assign empty   = (count == '0);
    assign do_push = push && !full;
    assign do_pop  = pop && !empty;

    always_ff @(posedge clk) begin
        if (!rst_n) begin
            wr_ptr <= '0;
            rd_ptr <= '0;
            count  <= '0;
        end else begin
            if (do_push) wr_ptr <= step_ptr(wr_ptr);
            if (do_pop)  rd_ptr <= step_ptr(rd_ptr);
            unique case ({do_push, do_pop})
                2'b10:   count <= count + 1'b1;
                2'b01:   count <= count - 1'b1;
                default: count <= count;
            endcase
        end
    end

    always_ff @(posedge clk) begin
        if (do_push) slots[wr_ptr] <= push_word;
    end

    assign head_word = slots[rd_ptr];
    assign level     = count;

    AST_NO_OVERFLOW: assert property (@(posedge clk) disable iff (!rst_n)
        (full && !pop) |=> $stable(count)); // R4

    AST_PUSH_COUNTS: assert property (@(posedge clk) disable iff (!rst_n)
        (push && !full && !pop) |=> (count == $past(count) + 1'b1)); // R2

    AST_POP_EMPTY: assert property (@(posedge clk) disable iff (!rst_n)
        (empty && pop && !push) |=> (count == '0)); // R7

    AST_BOTH_HOLD: assert property (@(posedge clk) disable iff (!rst_n)
        (push && pop && !full && !empty) |=> $stable(count)); // R8

endmodule

// File: rtl/tx_word_buffer.sv
module tx_word_buffer #(
    parameter int DEPTH  = 8,
    parameter int WORD_W = 31,
    parameter int BUS_W  = 16
) (
    input  logic                       clk,
    input  logic                       rst_n,
    input  logic [BUS_W-1:0]           host_data,
    input  logic                       load_lo,
    input  logic                       load_hi,
    input  logic                       pop_req,
    output logic [WORD_W-1:0]          head_word,
    output logic [$clog2(DEPTH+1)-1:0] level,
    output logic                       full,
    output logic                       tx_ready
);

    logic              commit;
    logic [WORD_W-1:0] commit_word;
    logic              store_full;
    logic              store_empty;

    tx_half_fsm #(
        .WORD_W (WORD_W),
        .BUS_W  (BUS_W)
    ) u_half (
        .clk         (clk),
        .rst_n       (rst_n),
        .host_data   (host_data),
        .load_lo     (load_lo),
        .load_hi     (load_hi),
        .store_full  (store_full),
        .commit      (commit),
        .commit_word (commit_word)
    );

    tx_word_store #(
        .DEPTH  (DEPTH),
        .WORD_W (WORD_W)
    ) u_store (
        .clk       (clk),
        .rst_n     (rst_n),
        .push      (commit),
        .push_word (commit_word),
        .pop       (pop_req),
        .head_word (head_word),
        .level     (level),
        .full      (store_full),
        .empty     (store_empty)
    );

    assign full     = store_full;
    assign tx_ready = store_empty;

    AST_READY_RISES: assert property (@(posedge clk) disable iff (!rst_n)
        (level == 1 && pop_req && !commit) |=> tx_ready); // R6

    AST_READY_FALLS: assert property (@(posedge clk) disable iff (!rst_n)
        (tx_ready && commit) |=> !tx_ready); // R6

endmodule

// File: tb/tx_word_buffer_tb.sv
`timescale 1ns/1ps
module tx_word_buffer_tb_top;

    localparam int DEPTH  = 8;
    localparam int WORD_W = 31;
    localparam int BUS_W  = 16;

    localparam logic [1:0] OP_NOP = 2'd0;
    localparam logic [1:0] OP_LO  = 2'd1;
    localparam logic [1:0] OP_HI  = 2'd2;
    localparam logic [1:0] OP_POP = 2'd3;

    // {op, data, level, ready, check_head, head}
    localparam int NVEC = 13;
    localparam logic [54:0] VEC [NVEC] = '{
        {OP_HI,  16'h1234, 4'd0, 1'b1, 1'b0, 31'h0},        // R3 orphan
        {OP_LO,  16'h1111, 4'd0, 1'b1, 1'b0, 31'h0},        // R2
        {OP_HI,  16'h0AAA, 4'd1, 1'b0, 1'b1, 31'h0AAA1111}, // R2 R6
        {OP_HI,  16'h0CCC, 4'd1, 1'b0, 1'b1, 31'h0AAA1111}, // R3
        {OP_LO,  16'h2222, 4'd1, 1'b0, 1'b1, 31'h0AAA1111}, // R5
        {OP_LO,  16'h3333, 4'd1, 1'b0, 1'b1, 31'h0AAA1111}, // R5
        {OP_HI,  16'h0BBB, 4'd2, 1'b0, 1'b1, 31'h0AAA1111}, // R8
        {OP_POP, 16'h0000, 4'd1, 1'b0, 1'b1, 31'h0BBB3333}, // R5 R7
        {OP_LO,  16'h0005, 4'd1, 1'b0, 1'b1, 31'h0BBB3333},
        {OP_HI,  16'h8001, 4'd2, 1'b0, 1'b1, 31'h0BBB3333}, // R9
        {OP_POP, 16'h0000, 4'd1, 1'b0, 1'b1, 31'h00010005}, // R9
        {OP_POP, 16'h0000, 4'd0, 1'b1, 1'b0, 31'h0},        // R6
        {OP_POP, 16'h0000, 4'd0, 1'b1, 1'b0, 31'h0}         // R7 empty pop
    };

    logic                 clk = 1'b0;
    logic                 rst_n = 1'b0;
    logic [BUS_W-1:0]     host_data = '0;
    logic                 load_lo = 1'b0;
    logic                 load_hi = 1'b0;
    logic                 pop_req = 1'b0;
    logic [WORD_W-1:0]    head_word;
    logic [3:0]           level;
    logic                 full;
    logic                 tx_ready;

    int n_checks = 0;
    int n_errors = 0;

    always #2.5 clk = ~clk;

    tx_word_buffer #(
        .DEPTH  (DEPTH),
        .WORD_W (WORD_W),
        .BUS_W  (BUS_W)
    ) dut_i (
        .clk       (clk),
        .rst_n     (rst_n),
        .host_data (host_data),
        .load_lo   (load_lo),
        .load_hi   (load_hi),
        .pop_req   (pop_req),
        .head_word (head_word),
        .level     (level),
        .full      (full),
        .tx_ready  (tx_ready)
    );

    task automatic chk(input string req, input logic [31:0] act, input logic [31:0] exp);
        n_checks++;
        if (act !== exp) begin
            n_errors++;
            $display("FAIL %s actual=%h expected=%h", req, act, exp);
        end
    endtask

    // Drive for one edge, then sample 1 ns after it
    task automatic cyc(input logic lo, input logic hi, input logic pp, input logic [15:0] d);
        @(negedge clk);
        load_lo   = lo;
        load_hi   = hi;
        pop_req   = pp;
        host_data = d;
        @(posedge clk);
        #1;
        load_lo = 1'b0;
        load_hi = 1'b0;
        pop_req = 1'b0;
    endtask

    initial begin
        #(200000 * 5);
        n_errors++;
        n_checks++;
        $display("FAIL R1 watchdog actual=running expected=done");
        $display("  Result: errors=%0d of %0d checks", n_errors, n_checks);
        $finish;
    end

    initial begin
        repeat (3) @(posedge clk);
        #1;
        chk("R1 level", 32'(level), 32'd0);
        chk("R1 ready", 32'(tx_ready), 32'd1);
        chk("R1 full", 32'(full), 32'd0);
        @(negedge clk);
        rst_n = 1'b1;

        // Vector table
        for (int i = 0; i < NVEC; i++) begin
            logic [1:0] op;
            op = VEC[i][54:53];
            cyc(op == OP_LO, op == OP_HI, op == OP_POP, VEC[i][52:37]);
            chk($sformatf("R2/R3/R5/R7/R9 vec%0d level", i), 32'(level), 32'(VEC[i][36:33]));
            chk($sformatf("R6 vec%0d ready", i), 32'(tx_ready), 32'(VEC[i][32]));
            if (VEC[i][31])
                chk($sformatf("R7/R8 vec%0d head", i), 32'(head_word), 32'(VEC[i][30:0]));
        end

        // R4: fill to capacity, then try more loads
        for (int i = 0; i < DEPTH; i++) begin
            cyc(1'b1, 1'b0, 1'b0, 16'(i + 16'h0040));
            cyc(1'b0, 1'b1, 1'b0, 16'(i + 16'h0100));
        end
        chk("R4 level at capacity", 32'(level), 32'(DEPTH));
        chk("R4 full flag", 32'(full), 32'd1);
        cyc(1'b1, 1'b0, 1'b0, 16'hEEEE);
        cyc(1'b0, 1'b1, 1'b0, 16'h0EEE);
        chk("R4 level after rejected loads", 32'(level), 32'(DEPTH));
        chk("R4 head after rejected loads", 32'(head_word), 32'h01000040);

        // R8: drain in commit order
        for (int i = 0; i < DEPTH; i++) begin
            logic [30:0] exp_w;
            exp_w = {15'(16'h0100 + i), 16'(16'h0040 + i)};
            chk($sformatf("R8 order word%0d", i), 32'(head_word), 32'(exp_w));
            cyc(1'b0, 1'b0, 1'b1, 16'h0);
        end
        chk("R6 ready after drain", 32'(tx_ready), 32'd1);
        chk("R4 full clear after drain", 32'(full), 32'd0);

        // R8: commit and pop on the same edge
        cyc(1'b1, 1'b0, 1'b0, 16'h00AA);
        cyc(1'b0, 1'b1, 1'b0, 16'h0001);
        cyc(1'b1, 1'b0, 1'b0, 16'h00BB);
        cyc(1'b0, 1'b1, 1'b1, 16'h0002);
        chk("R8 level with push+pop", 32'(level), 32'd1);
        chk("R8 head after push+pop", 32'(head_word), 32'h000200BB);

        // R10: both strobes with nothing pending -> capture only
        cyc(1'b1, 1'b1, 1'b0, 16'h0044);
        chk("R10 both in wait state no commit", 32'(level), 32'd1);
        cyc(1'b0, 1'b1, 1'b0, 16'h0005);
        chk("R10 captured low half commits", 32'(level), 32'd2);
        cyc(1'b0, 1'b0, 1'b1, 16'h0);
        chk("R10 word from both-strobe capture", 32'(head_word), 32'h00050044);
        // R10: both strobes with a half pending -> commit, low dropped
        cyc(1'b1, 1'b0, 1'b0, 16'h0077);
        cyc(1'b1, 1'b1, 1'b0, 16'h0009);
        chk("R10 both in hold state commits", 32'(level), 32'd2);
        cyc(1'b0, 1'b1, 1'b0, 16'h0003);
        chk("R10 dropped low half leaves nothing pending", 32'(level), 32'd2);
        cyc(1'b0, 1'b0, 1'b1, 16'h0);
        chk("R10 committed word", 32'(head_word), 32'h00090077);

        // R1: reset with a stored word and a pending low half
        cyc(1'b1, 1'b0, 1'b0, 16'h1234);
        @(negedge clk);
        rst_n = 1'b0;
        @(posedge clk);
        #1;
        chk("R1 reset empties", 32'(level), 32'd0);
        chk("R1 reset ready", 32'(tx_ready), 32'd1);
        @(negedge clk);
        rst_n = 1'b1;
        cyc(1'b0, 1'b1, 1'b0, 16'h0001);
        chk("R1 pending half cleared", 32'(level), 32'd0);

        $display("  Result: errors=%0d of %0d checks", n_errors, n_checks);
        $finish;
    end

endmodule